// File: doc/BRIEF.md
# UART Auto-Baud Measurement and Break Generator

This unit is the baud-detection and break-generation part of an enhanced UART receiver/transmitter pair. Software arms a measurement through a small configuration write port. The unit then waits for a clean idle-high line on RX. It times one 0x55 sync character by counting system clocks from its first to its fifth rising edge. The count is scaled down to a baud divisor and loaded into an 8-bit or 16-bit divisor register, depending on the width-mode bit. When the measurement completes, the arm bit drops and a sticky done flag is raised. If the count runs past what the selected divisor width can hold, a sticky overflow flag is raised instead, and the old divisor is kept.

The same write port can request a sync break on TX. The break is a run of low bit-times followed by a high stop bit, timed with the current divisor. The request bit clears itself when the stop bit ends. A shifter-idle flag also shows when the transmit side has gone quiet. While a measurement is armed, serial data from the external data shifter is kept off TX, so the line stays high. The receiver-enable bit belongs to software alone: a finished measurement does not change it.

Top module: `uart_autobaud_break`

## Requirements
- R1: A configuration write with bit 0 (arm) set while not armed clears the done and overflow flags. Timing does not begin until RX has been seen high and then low, so arming while RX is low and then releasing RX high does not start a count.
- R2: The clock count C runs from the first to the fifth rising edge of the sync character. At the end, the divisor is C >> DIV_SHIFT (with the default shift of 3, this is clocks per bit), arm reads 0 and done reads 1.
- R3: With bit 1 (wide) clear, completion loads only the low divisor byte; the high byte keeps its previous value.
- R4: With the wide bit set, completion loads both divisor bytes, high byte from result bits 15:8.
- R5: The receiver-enable bit (bit 3) changes only on a configuration write; completion of a measurement leaves it as written.
- R6: While armed, TX is held high even with the transmitter enabled (bit 4), the shifter busy and shifter data low. When not armed, with the transmitter enabled and the shifter busy, TX follows the shifter data.
- R7: If the count reaches (256 << DIV_SHIFT) - 1 in narrow mode (or all ones in wide mode) before the fifth edge, overflow reads 1, arm reads 0, done stays 0 and both divisor bytes are unchanged.
- R8: A write with bit 2 (break) set starts a break, unless the shifter is busy. TX goes low for 13×P clocks and then high for P clocks. P is the active divisor: the low byte in narrow mode, both bytes in wide mode, and 0 is taken as 1.
- R9: The break bit reads 1 from the write until the stop bit ends, then clears by itself. The shifter-idle flag is low while a break is pending or running, and high afterwards when the shifter is idle.
- R10: A break write that lands in the very cycle the break bit self-clears is kept as a new request. The break bit stays 1, TX is high for one clock, and a new break starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | {xmt_en, rcv_en, break, wide, arm}, arm in bit 0 |
| arm_o | output | 1 | Measurement armed |
| wide_o | output | 1 | 16-bit divisor mode |
| brk_o | output | 1 | Break request pending or running |
| rcv_en_o | output | 1 | Receiver enable as written |
| xmt_en_o | output | 1 | Transmitter enable as written |
| tsr_empty_o | output | 1 | Transmit side idle (no break, shifter idle) |
| done_o | output | 1 | Sticky measurement-complete flag |
| ovf_o | output | 1 | Sticky measurement-overflow flag |
| rx_i | input | 1 | Serial receive line |
| sh_txd_i | input | 1 | Serial bit from the external data shifter |
| sh_busy_i | input | 1 | External data shifter is sending |
| tx_o | output | 1 | Serial transmit line |
| div_lo_o | output | 8 | Divisor low byte |
| div_hi_o | output | 8 | Divisor high byte |

## Verification
The break bit can be written by software in the same cycle the generator's stop bit ends and hardware clears it. The bench measures the first break's low and high phases to find that exact clock. It then lands a second break write on it and judges the result at the pins: the break bit must stay set, TX must show a single high clock, and TX must then fall again. A second overlap covers the measurement and the transmitter. The shifter is driven busy with low data across an armed measurement, and TX is observed high throughout the arm window and then following the shifter once arm drops.

// File: rtl/uart_abd_pkg.sv
package uart_abd_pkg;

   // Configuration word, arm lands in bit 0.
   typedef struct packed {
      logic xmt_en;
      logic rcv_en;
      logic brk;
      logic wide;
      logic arm;
   } cfg_t;

   localparam int CFG_W      = $bits(cfg_t);
   localparam int SYNC_RISES = 5;    // rising edges in a 0x55 frame incl. stop
   localparam int DIV_BYTES  = 2;
   localparam int DIV_W      = 8 * DIV_BYTES;

   typedef enum logic [2:0] {
      M_IDLE,
      M_WAIT_HIGH,
      M_WAIT_LOW,
      M_WAIT_RISE,
      M_COUNT
   } meas_st_t;

endpackage

// File: rtl/uart_abd_sync.sv
module uart_abd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin : elab_chk
      if (STAGES < 1) $fatal(1, "uart_abd_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] pipe;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_abd_meas.sv
module uart_abd_meas
   import uart_abd_pkg::*;
#(
   parameter int SHIFT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_s,
   input  logic             start,
   input  logic             abort,
   input  logic             wide,
   output logic             busy,
   output logic             fin,
   output logic             oflow,
   output logic [DIV_W-1:0] result
);
   localparam int CNT_W = DIV_W + SHIFT;
   localparam int EDG_W = $clog2(SYNC_RISES);
   localparam logic [CNT_W-1:0] LIM_NARROW = CNT_W'((64'd256 << SHIFT) - 64'd1);
   localparam logic [CNT_W-1:0] LIM_WIDE   = '1;
   localparam logic [EDG_W-1:0] EDG_LAST   = EDG_W'(SYNC_RISES - 2);

   meas_st_t         st, st_n;
   logic [CNT_W-1:0] cnt, cnt_n, lim;
   logic [EDG_W-1:0] edg, edg_n;
   logic [CNT_W:0]   total;
   logic             rx_d, rise;

   assign rise   = rx_s & ~rx_d;
   assign lim    = wide ? LIM_WIDE : LIM_NARROW;
   assign total  = {1'b0, cnt} + 1'b1;
   assign result = DIV_W'(total >> SHIFT);
   assign busy   = (st != M_IDLE);

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      edg_n = edg;
      fin   = 1'b0;
      oflow = 1'b0;
      case (st)
         M_IDLE:      if (start) st_n = M_WAIT_HIGH;
         M_WAIT_HIGH: if (rx_s)  st_n = M_WAIT_LOW;
         M_WAIT_LOW:  if (!rx_s) st_n = M_WAIT_RISE;
         M_WAIT_RISE: if (rx_s) begin
            st_n  = M_COUNT;
            cnt_n = '0;
            edg_n = '0;
         end
         M_COUNT: begin
            if (cnt == lim) begin
               oflow = 1'b1;
               st_n  = M_IDLE;
            end else if (rise && edg == EDG_LAST) begin
               fin  = 1'b1;
               st_n = M_IDLE;
            end else begin
               cnt_n = cnt + 1'b1;
               if (rise) edg_n = edg + 1'b1;
            end
         end
         default: st_n = M_IDLE;
      endcase
      if (abort && st != M_IDLE) begin
         st_n  = M_IDLE;
         fin   = 1'b0;
         oflow = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= M_IDLE;
         cnt  <= '0;
         edg  <= '0;
         rx_d <= 1'b1;
      end else begin
         st   <= st_n;
         cnt  <= cnt_n;
         edg  <= edg_n;
         rx_d <= rx_s;
      end
   end
endmodule

// File: rtl/uart_abd_brk.sv
module uart_abd_brk #(
   parameter int LOW_BITS  = 13,
   parameter int STOP_BITS = 1,
   parameter int PER_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [PER_W-1:0] period,
   output logic             active,
   output logic             low,
   output logic             fin
);
   localparam int TOT  = LOW_BITS + STOP_BITS;
   localparam int BC_W = $clog2(TOT + 1);

   logic [PER_W-1:0] tcnt, per_m1;
   logic [BC_W-1:0]  bcnt;

   assign per_m1 = (period == '0) ? '0 : period - 1'b1;
   assign fin    = active && (bcnt == BC_W'(TOT - 1)) && (tcnt == per_m1);
   assign low    = active && (bcnt < BC_W'(LOW_BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         tcnt   <= '0;
         bcnt   <= '0;
      end else if (!active) begin
         if (go) begin
            active <= 1'b1;
            tcnt   <= '0;
            bcnt   <= '0;
         end
      end else if (fin) begin
         active <= 1'b0;
      end else if (tcnt == per_m1) begin
         tcnt <= '0;
         bcnt <= bcnt + 1'b1;
      end else begin
         tcnt <= tcnt + 1'b1;
      end
   end
endmodule

// File: rtl/uart_autobaud_break.sv
module uart_autobaud_break
   import uart_abd_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int DIV_SHIFT     = 3,
   parameter int BRK_LOW_BITS  = 13,
   parameter int BRK_STOP_BITS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             arm_o,
   output logic             wide_o,
   output logic             brk_o,
   output logic             rcv_en_o,
   output logic             xmt_en_o,
   output logic             tsr_empty_o,
   output logic             done_o,
   output logic             ovf_o,
   input  logic             rx_i,
   input  logic             sh_txd_i,
   input  logic             sh_busy_i,
   output logic             tx_o,
   output logic [7:0]       div_lo_o,
   output logic [7:0]       div_hi_o
);
   initial begin : elab_chk
      if (DIV_SHIFT < 0 || DIV_SHIFT > 8)
         $fatal(1, "uart_autobaud_break: DIV_SHIFT out of range");
      if (BRK_LOW_BITS < 1 || BRK_STOP_BITS < 1)
         $fatal(1, "uart_autobaud_break: break lengths must be positive");
   end

   cfg_t             wr;
   logic             rx_s, armed, m_fin, m_ovf, start, abort;
   logic [DIV_W-1:0] m_res, brk_per;
   logic             wide_q, rcv_q, xmt_q, brk_q, done_q, ovf_q;
   logic [7:0]       lo_q, hi_q;
   logic             b_go, b_active, b_low, b_fin;

   assign wr    = cfg_t'(cfg_wdata);
   assign start = cfg_we & wr.arm & ~armed;
   assign abort = cfg_we & ~wr.arm;

   uart_abd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_i), .q(rx_s)
   );

   uart_abd_meas #(.SHIFT(DIV_SHIFT)) u_meas (
      .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .start(start), .abort(abort),
      .wide(wide_q), .busy(armed), .fin(m_fin), .oflow(m_ovf), .result(m_res)
   );

   assign brk_per = wide_q ? {hi_q, lo_q} : {8'h00, lo_q};
   assign b_go    = brk_q & ~b_active & ~sh_busy_i;

   uart_abd_brk #(
      .LOW_BITS(BRK_LOW_BITS), .STOP_BITS(BRK_STOP_BITS), .PER_W(DIV_W)
   ) u_brk (
      .clk(clk), .rst_n(rst_n), .go(b_go), .period(brk_per),
      .active(b_active), .low(b_low), .fin(b_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_q <= 1'b0;
         rcv_q  <= 1'b0;
         xmt_q  <= 1'b0;
         brk_q  <= 1'b0;
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         if (cfg_we) begin
            wide_q <= wr.wide;
            rcv_q  <= wr.rcv_en;
            xmt_q  <= wr.xmt_en;
         end
         if (cfg_we && wr.brk) brk_q <= 1'b1;
         else if (b_fin)       brk_q <= 1'b0;
         if (start) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
         end else begin
            if (m_fin) done_q <= 1'b1;
            if (m_ovf) ovf_q  <= 1'b1;
         end
         if (m_fin) begin
            lo_q <= m_res[7:0];
            if (wide_q) hi_q <= m_res[15:8];
         end
      end
   end

   always_comb begin
      if (b_active)                       tx_o = ~b_low;
      else if (xmt_q & ~armed & sh_busy_i) tx_o = sh_txd_i;
      else                                tx_o = 1'b1;
   end

   assign arm_o       = armed;
   assign wide_o      = wide_q;
   assign brk_o       = brk_q;
   assign rcv_en_o    = rcv_q;
   assign xmt_en_o    = xmt_q;
   assign tsr_empty_o = ~brk_q & ~b_active & ~sh_busy_i;
   assign done_o      = done_q;
   assign ovf_o       = ovf_q;
   assign div_lo_o    = lo_q;
   assign div_hi_o    = hi_q;
endmodule

// File: rtl/uart_autobaud_break_chk.sv
module uart_autobaud_break_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic       arm_o,
   input logic       wide_o,
   input logic       brk_o,
   input logic       rcv_en_o,
   input logic       xmt_en_o,
   input logic       tsr_empty_o,
   input logic       done_o,
   input logic       ovf_o,
   input logic       sh_busy_i,
   input logic       tx_o,
   input logic [7:0] div_lo_o,
   input logic [7:0] div_hi_o
);
   p_done_drops_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> !arm_o);

   p_narrow_keeps_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) && !$past(wide_o) |-> $stable(div_hi_o));

   p_rcv_sw_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(rcv_en_o));

   p_tx_quiet_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      arm_o && !brk_o |-> tx_o);

   p_no_overflow_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> $stable(div_lo_o) && $stable(div_hi_o));

   p_tx_low_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_o |-> brk_o || (xmt_en_o && !arm_o && sh_busy_i));

   p_brk_clear_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brk_o) && !sh_busy_i |-> tsr_empty_o);
endmodule

bind uart_autobaud_break uart_autobaud_break_chk u_chk (.*);

// File: tb/uart_autobaud_break_test.sv
`timescale 1ns/1ps
module uart_autobaud_break_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [4:0] cfg_wdata = '0;
   logic       rx_i = 1'b1;
   logic       sh_txd_i = 1'b1;
   logic       sh_busy_i = 1'b0;
   logic       arm_o, wide_o, brk_o, rcv_en_o, xmt_en_o, tsr_empty_o, done_o, ovf_o, tx_o;
   logic [7:0] div_lo_o, div_hi_o;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   always #4 clk = ~clk;

   uart_autobaud_break uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .arm_o(arm_o), .wide_o(wide_o), .brk_o(brk_o), .rcv_en_o(rcv_en_o),
      .xmt_en_o(xmt_en_o), .tsr_empty_o(tsr_empty_o), .done_o(done_o),
      .ovf_o(ovf_o), .rx_i(rx_i), .sh_txd_i(sh_txd_i), .sh_busy_i(sh_busy_i),
      .tx_o(tx_o), .div_lo_o(div_lo_o), .div_hi_o(div_hi_o)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // fields: {xmt_en, rcv_en, brk, wide, arm}
   task automatic wr(input bit arm, input bit wide, input bit brk, input bit rcv, input bit xmt);
      cfg_wdata = {xmt, rcv, brk, wide, arm};
      cfg_we    = 1'b1;
      tick();
      cfg_we    = 1'b0;
   endtask

   task automatic send_sync(input int t);
      rx_i = 1'b0;
      repeat (t) tick();
      for (int b = 0; b < 8; b++) begin
         rx_i = (b % 2 == 0);
         repeat (t) tick();
      end
      rx_i = 1'b1;
      repeat (t) tick();
   endtask

   task automatic t_reset();
      chk("R2", "arm after reset", arm_o, 0);
      chk("R2", "done after reset", done_o, 0);
      chk("R7", "ovf after reset", ovf_o, 0);
      chk("R9", "brk after reset", brk_o, 0);
      chk("R9", "tsr_empty after reset", tsr_empty_o, 1);
      chk("R6", "tx idle after reset", tx_o, 1);
      chk("R4", "divisor after reset", {div_hi_o, div_lo_o}, 0);
   endtask

   task automatic t_wide();
      wr(1, 1, 0, 0, 0);
      repeat (4) tick();
      send_sync(300);
      repeat (5) tick();
      chk("R2", "arm after wide run", arm_o, 0);
      chk("R2", "done after wide run", done_o, 1);
      chk("R4", "wide low byte", div_lo_o, 300 % 256);
      chk("R4", "wide high byte", div_hi_o, 300 / 256);
   endtask

   task automatic t_narrow_tx();
      sh_busy_i = 1'b1;
      sh_txd_i  = 1'b0;
      wr(1, 0, 0, 1, 1);
      chk("R1", "done cleared on arm", done_o, 0);
      repeat (2) tick();
      chk("R6", "tx high while armed", tx_o, 1);
      send_sync(7);
      repeat (5) tick();
      chk("R2", "narrow divisor", div_lo_o, 7);
      chk("R3", "high byte kept", div_hi_o, 1);
      chk("R5", "rcv_en kept after completion", rcv_en_o, 1);
      chk("R6", "tx follows shifter after arm drops", tx_o, 0);
      sh_busy_i = 1'b0;
      sh_txd_i  = 1'b1;
   endtask

   task automatic t_overflow();
      wr(1, 0, 0, 1, 0);
      repeat (4) tick();
      send_sync(300);
      repeat (5) tick();
      chk("R7", "ovf set", ovf_o, 1);
      chk("R7", "done stays low", done_o, 0);
      chk("R7", "arm cleared", arm_o, 0);
      chk("R7", "divisor unchanged", {div_hi_o, div_lo_o}, 256 + 7);
   endtask

   task automatic t_arm_low();
      rx_i = 1'b0;
      wr(1, 0, 0, 1, 0);
      repeat (20) tick();
      chk("R1", "ovf cleared on arm", ovf_o, 0);
      chk("R1", "still armed with rx low", arm_o, 1);
      rx_i = 1'b1;
      repeat (10) tick();
      chk("R1", "still armed after rx release", arm_o, 1);
      send_sync(9);
      repeat (5) tick();
      chk("R1", "divisor after low-line arm", div_lo_o, 9);
      chk("R2", "done after low-line arm", done_o, 1);
   endtask

   task automatic t_break(input int per);
      int lo_n = 0;
      int hi_n = 0;
      wr(0, 0, 1, 1, 0);
      chk("R9", "brk set after write", brk_o, 1);
      chk("R9", "tsr_empty low when pending", tsr_empty_o, 0);
      tick();
      while (tx_o == 1'b0 && lo_n < 5000) begin lo_n++; tick(); end
      while (brk_o == 1'b1 && tx_o == 1'b1 && hi_n < 5000) begin hi_n++; tick(); end
      chk("R8", "break low length", lo_n, 13 * per);
      chk("R8", "break stop length", hi_n, per);
      chk("R9", "brk self-cleared", brk_o, 0);
      chk("R9", "tsr_empty after break", tsr_empty_o, 1);
   endtask

   task automatic t_collide(input int per);
      int lo_n = 0;
      wr(0, 0, 1, 1, 0);
      tick();
      while (tx_o == 1'b0 && lo_n < 5000) begin lo_n++; tick(); end
      chk("R10", "first break low length", lo_n, 13 * per);
      repeat (per - 1) tick();
      wr(0, 0, 1, 1, 0);
      chk("R10", "brk kept at clear cycle", brk_o, 1);
      chk("R10", "one idle clock between breaks", tx_o, 1);
      tick();
      chk("R10", "second break starts", tx_o, 0);
      for (int i = 0; i < 5000 && brk_o; i++) tick();
      chk("R10", "second break ends", brk_o, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_wide();
      t_narrow_tx();
      t_overflow();
      t_arm_low();
      t_break(9);
      t_collide(9);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule